// File: doc/BRIEF.md
# Bidirectional On-the-Fly Round-Key Scheduler

This block generates the round keys of a seven-round, 128-bit cipher that uses the AES key-expansion recurrence. It holds one 128-bit key in four 32-bit word registers and replaces the whole key with the next one on every clock. No round key is stored. The cipher datapath reads each key in the cycle it is produced.

In encrypt mode the scheduler is loaded with the cipher key and steps forward through rounds 1 to 7. After the last step the final round key stays in the registers. In decrypt mode the scheduler is loaded with that final key and undoes the recurrence one round per clock. The round keys then come out in reverse order, ending with the cipher key. Both directions share the same registers and the same single SubWord path. Only the order of the XOR chain differs between the two directions.

Top module: `bidir_key_sched`

## Requirements
- R1: While reset is asserted and after it is released with no load, `round_key` is zero, `round_idx` is 0 and `done` is 0.
- R2: A cycle with `load` high captures `init_key` into `round_key` at the next clock edge. The same edge sets `round_idx` to 0 when `enc_mode` is 1 (encrypt) or to 7 when it is 0 (decrypt).
- R3: Each forward step applies the AES-128 recurrence. Word 0 is bits [127:96]. Word 0 becomes w0 ^ SubWord(RotWord(w3)) ^ Rcon, where Rcon sits in the top byte. Each later word becomes the new word before it XOR its own old value. For an all-zero cipher key, round 1 is 62636363 in all four words.
- R4: In encrypt mode `round_idx` rises by one on each clock after the load, from 0 to 7. The step into round r uses Rcon = 2^(r-1) in GF(2^8), which gives 01, 02, 04, 08, 10, 20, 40.
- R5: `done` is high for exactly one cycle, the cycle in which the seventh step's key is visible. At that point `round_idx` is 7 in encrypt mode and 0 in decrypt mode.
- R6: After a run has finished, `round_key` and `round_idx` hold their values until the next load. Changes on `enc_mode` and `init_key` while `load` is low have no effect.
- R7: In decrypt mode, starting from the final forward key, each clock produces the key of the previous round, with `round_idx` falling from 7 to 0. Word 3 is recovered first as w2 ^ w3, then word 2 as w1 ^ w2, then word 1 as w0 ^ w1. Word 0 is recovered last, as w0 ^ SubWord(RotWord(new w3)) ^ Rcon of the current round index.
- R8: A load in the middle of a run restarts the scheduler from the new key and mode. No `done` pulse is produced for the run that was abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Start strobe; captures `init_key` and `enc_mode` |
| enc_mode | input | 1 | 1 = forward expansion, 0 = reverse expansion |
| init_key | input | 128 | Cipher key (encrypt) or final round key (decrypt) |
| round_key | output | 128 | Current round key, word 0 in bits [127:96] |
| round_idx | output | 3 | Index of the round key currently presented |
| done | output | 1 | One-cycle pulse when the last round key is presented |

## Verification
A wrong word in the key registers shows up on `round_key` in the very next cycle, and every later round inherits the error. A corrupt S-box entry or Rcon byte therefore spreads into all four words within one or two steps. The fastest detector is the round trip: a forward run is fed back in decrypt mode, and every reverse key is compared against the forward key recorded for the same index. A fault in either direction makes the two sequences differ no later than the seventh cycle. Published AES-128 expansion values pin the forward direction independently. Checks in the idle cycles after a run expose an index or `done` that does not stop.

// File: rtl/bidir_key_sched.sv
module bidir_key_sched #(
  parameter int ROUNDS = 7,
  parameter int KEY_W  = 128,
  localparam int WORD_W = KEY_W / 4,
  localparam int IDX_W  = $clog2(ROUNDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               enc_mode,
  input  logic [KEY_W-1:0]   init_key,
  output logic [KEY_W-1:0]   round_key,
  output logic [IDX_W-1:0]   round_idx,
  output logic               done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS);

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gmul(r, r);
      if (i != 0) r = gmul(r, a);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = ginv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] rcon(input logic [IDX_W-1:0] n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i <= ROUNDS; i++)
      if (i < int'(n)) r = xtime(r);
    return r;
  endfunction

  logic [KEY_W-1:0] key_q;
  logic [IDX_W-1:0] idx_q;
  logic             fwd_q, busy_q, done_q;

  logic [WORD_W-1:0] w0, w1, w2, w3;
  assign {w0, w1, w2, w3} = key_q;

  // reverse chain: words 3..1 first, word 3 feeds the substitution
  logic [WORD_W-1:0] r1, r2, r3;
  assign r3 = w2 ^ w3;
  assign r2 = w1 ^ w2;
  assign r1 = w0 ^ w1;

  // one shared SubWord path, input picked by direction
  logic [WORD_W-1:0] sw_src, sw_rot, sw_out;
  assign sw_src = fwd_q ? w3 : r3;
  assign sw_rot = {sw_src[WORD_W-9:0], sw_src[WORD_W-1 -: 8]};

  for (genvar g = 0; g < WORD_W / 8; g++) begin : g_sbox
    assign sw_out[g*8 +: 8] = sbox(sw_rot[g*8 +: 8]);
  end

  logic [7:0]        rc;
  logic [WORD_W-1:0] mix0;
  assign rc   = rcon(fwd_q ? idx_q + 1'b1 : idx_q);
  assign mix0 = w0 ^ sw_out ^ {rc, {(WORD_W-8){1'b0}}};

  logic [WORD_W-1:0] f0, f1, f2, f3;
  assign f0 = mix0;
  assign f1 = f0 ^ w1;
  assign f2 = f1 ^ w2;
  assign f3 = f2 ^ w3;

  logic [KEY_W-1:0] key_nxt;
  assign key_nxt = fwd_q ? {f0, f1, f2, f3} : {mix0, r1, r2, r3};

  logic last_step;
  assign last_step = fwd_q ? (idx_q == LAST - 1'b1) : (idx_q == IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      idx_q  <= '0;
      fwd_q  <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load) begin
      key_q  <= init_key;
      fwd_q  <= enc_mode;
      idx_q  <= enc_mode ? '0 : LAST;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        key_q <= key_nxt;
        idx_q <= fwd_q ? idx_q + 1'b1 : idx_q - 1'b1;
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign round_key = key_q;
  assign round_idx = idx_q;
  assign done      = done_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> round_key == $past(init_key)); // R2
  AST_LOAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> round_idx == ($past(enc_mode) ? '0 : LAST)); // R2
  AST_FWD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && fwd_q && !load |=> (round_key[KEY_W-1 -: WORD_W] ^ round_key[KEY_W-WORD_W-1 -: WORD_W]) == $past(round_key[KEY_W-WORD_W-1 -: WORD_W])); // R3
  AST_FWD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && fwd_q && !load |=> round_idx == $past(round_idx) + 1'b1); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> !done); // R5
  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> round_idx == (fwd_q ? LAST : '0)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !load |=> $stable(round_key) && $stable(round_idx)); // R6
  AST_REV_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !fwd_q && !load |=> round_idx == $past(round_idx) - 1'b1); // R7

endmodule

// File: tb/bidir_key_sched_tb.sv
module bidir_key_sched_tb_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         load = 0;
  logic         enc_mode = 1;
  logic [127:0] init_key = '0;
  logic [127:0] round_key;
  logic [2:0]   round_idx;
  logic         done;

  int checks = 0;
  int errors = 0;
  logic [127:0] fwd_keys [0:7];

  always #2 clk = ~clk;

  bidir_key_sched dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .enc_mode(enc_mode),
    .init_key(init_key), .round_key(round_key), .round_idx(round_idx), .done(done)
  );

  // published AES-128 expansion of key 2b7e1516..., rounds 0..7
  localparam logic [127:0] VEC_RK [0:7] = '{
    128'h2b7e151628aed2a6abf7158809cf4f3c,
    128'ha0fafe1788542cb123a339392a6c7605,
    128'hf2c295f27a96b9435935807a7359f67f,
    128'h3d80477d4716fe3e1e237e446d7a883b,
    128'hef44a541a8525b7fb671253bdb0bad00,
    128'hd4d1c6f87c839d87caf2b8bc11f915bc,
    128'h6d88a37a110b3efddbf98641ca0093fd,
    128'h4e54f70e5f5fc9f384a64fb24ea6dc4f
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start(input logic [127:0] k, input logic enc);
    @(negedge clk);
    init_key = k; enc_mode = enc; load = 1;
    @(negedge clk);
    load = 0;
  endtask

  // forward run; records keys; returns after done cycle
  task automatic run_fwd(input logic [127:0] k);
    start(k, 1'b1);
    fwd_keys[0] = round_key;
    chk("R2 load key", round_key, k);
    chk("R2 load idx", 128'(round_idx), 128'd0);
    for (int r = 1; r <= 7; r++) begin
      @(negedge clk);
      fwd_keys[r] = round_key;
      chk("R4 fwd idx", 128'(round_idx), 128'(r));
      chk("R5 done", 128'(done), 128'(r == 7));
    end
  endtask

  task automatic run_rev_compare(input logic [127:0] k);
    start(k, 1'b0);
    chk("R2 rev load idx", 128'(round_idx), 128'd7);
    chk("R7 rev start", round_key, fwd_keys[7]);
    for (int r = 6; r >= 0; r--) begin
      @(negedge clk);
      chk("R7 rev key", round_key, fwd_keys[r]);
      chk("R7 rev idx", 128'(round_idx), 128'(r));
      chk("R5 rev done", 128'(done), 128'(r == 0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset key", round_key, '0);
    chk("R1 reset idx", 128'(round_idx), 0);
    chk("R1 reset done", 128'(done), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle key", round_key, '0);
    chk("R1 idle done", 128'(done), 0);

    // vector walk: every forward round of the published expansion (R3, R4)
    run_fwd(VEC_RK[0]);
    for (int r = 0; r <= 7; r++) chk("R3 vector round", fwd_keys[r], VEC_RK[r]);

    // R6: idle hold, input changes ignored
    @(negedge clk);
    chk("R5 done low after pulse", 128'(done), 0);
    enc_mode = 0; init_key = ~VEC_RK[0];
    repeat (3) @(negedge clk);
    chk("R6 hold key", round_key, VEC_RK[7]);
    chk("R6 hold idx", 128'(round_idx), 7);
    chk("R6 no done", 128'(done), 0);

    // R7: reverse from the published final key
    run_rev_compare(VEC_RK[7]);
    @(negedge clk);
    chk("R6 rev hold", round_key, VEC_RK[0]);
    chk("R6 rev idx hold", 128'(round_idx), 0);

    // zero key: round 1 all 62636363 (R3), then round trip (R7)
    run_fwd('0);
    chk("R3 zero round1", fwd_keys[1], {4{32'h62636363}});
    run_rev_compare(fwd_keys[7]);

    // arbitrary key round trip
    run_fwd(128'h0123456789abcdeffedcba9876543210);
    run_rev_compare(fwd_keys[7]);

    // R8: restart mid-run, no done from abandoned run
    start(128'hffffffffffffffffffffffffffffffff, 1'b1);
    @(negedge clk); @(negedge clk);
    chk("R8 no done mid", 128'(done), 0);
    start(VEC_RK[0], 1'b1);
    chk("R8 restart key", round_key, VEC_RK[0]);
    chk("R8 restart idx", 128'(round_idx), 0);
    for (int r = 1; r <= 7; r++) begin
      @(negedge clk);
      chk("R8 restart seq", round_key, VEC_RK[r]);
      chk("R8 done timing", 128'(done), 128'(r == 7));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule